// File: doc/BRIEF.md
# Floating-Point Operand Unpack and Classify

This block takes one packed operand, as read from a register file, and rewrites it in the single internal form used by a floating-point datapath. That form is a sign bit, a signed unbiased exponent, a 128-bit mantissa with its integer bit at the top and the fraction left-aligned below it, and a class code. A type code selects one of five source formats: IEEE single, double or quad, or a 32-bit or 64-bit integer. For integers a separate flag chooses signed or unsigned.

Subnormal floats and integers leave the decoder with their leading one somewhere below the top bit. A priority leading-zero counter and a barrel shifter move that one to bit 127, and the shift count is taken off the exponent. A signalling NaN leaves the block with its quiet bit already set. It still carries a class of its own, and it raises the invalid-operation flag. The block is a two-stage pipeline. Input acceptance uses a valid/ready handshake, and each result appears exactly two cycles after its operand is accepted.

Top module: `fp_unpack`

## Requirements
- R1: Every format is aligned to the top of the 128-bit operand. Single uses bits 127:96, double uses 127:64 and quad uses 127:0. A 32-bit integer sits in 127:96 and a 64-bit integer in 127:64. Bits below the selected width have no effect. Type codes are 0 single, 1 double, 2 quad, 3 32-bit integer and 4 64-bit integer. The sign output always equals operand bit 127.
- R2: During reset, in_ready and out_valid are low. From the first cycle after reset, in_ready is high. An operand presented with in_valid and in_ready high in cycle n gives out_valid high in cycle n+2, and out_valid is low in every cycle without such an acceptance. Back-to-back operands give back-to-back results.
- R3: A float with an all-zero exponent field and a zero fraction, or an integer with a value of zero, gives class 0 (zero), with exponent 0 and mantissa 0.
- R4: A float with an exponent field that is neither zero nor all ones gives class 1 (number). The exponent is the field minus the bias (127, 1023 or 16383). Mantissa bit 127 is one, the fraction follows from bit 126 downward, and the remaining bits are zero.
- R5: A float with a zero exponent field and a nonzero fraction gives class 1. Its mantissa is shifted left until bit 127 is one, and its exponent is 1 minus the bias minus that shift.
- R6: A float with an all-ones exponent field and a zero fraction gives class 2 (infinity), with exponent 0 and mantissa 0.
- R7: A float with an all-ones exponent field and a nonzero fraction whose top bit is set gives class 3 (quiet NaN). The fraction is placed unchanged from bit 126 downward, mantissa bit 127 is zero and the exponent is 0.
- R8: A NaN whose fraction top bit is clear gives class 4 (signalling NaN). Its mantissa matches R7 except that bit 126 is forced to one, and out_invalid is high. out_invalid is low for every other result.
- R9: With in_signed high, a negative integer is converted to its magnitude, and the sign output is one. The most negative value keeps magnitude 2^31 or 2^63. With in_signed low, the integer is read as unsigned.
- R10: A nonzero integer gives class 1. Its mantissa has the magnitude shifted so that bit 127 is one, and its exponent is 31 or 63 minus the shift, so that the value is the magnitude.
- R11: Type codes 5 to 7 give class 0, exponent 0, mantissa 0 and out_invalid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can accept an operand |
| in_operand | input | 128 | Packed operand, aligned to the top bit |
| in_type | input | 3 | Source format code |
| in_signed | input | 1 | Integer source is two's complement |
| out_valid | output | 1 | Result present |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | 18 | Signed unbiased exponent |
| out_mant | output | 128 | Mantissa with its integer bit at 127 |
| out_class | output | 3 | 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
Every result field, including out_valid, class, sign, exponent, mantissa and the invalid flag, is registered twice between the operand and the ports. So all fields are due together in the second cycle after acceptance. The bench drives inputs on the falling edge. It checks that out_valid is still low one falling edge later and samples every field at the second falling edge. A back-to-back pair confirms that two results follow in consecutive cycles, each at that same two-cycle distance. In-ready and out_valid are also sampled while reset is held and in the first cycle after it.

// File: rtl/fp_unpack_pkg.sv
package fp_unpack_pkg;
  localparam int OP_W    = 128;
  localparam int MANT_W  = 128;
  localparam int EXP_W   = 18;
  localparam int CNT_W   = $clog2(MANT_W);
  localparam int NUM_FLT = 3;
  localparam int NUM_INT = 2;

  typedef enum logic [2:0] {
    FMT_SP  = 3'd0,
    FMT_DP  = 3'd1,
    FMT_QP  = 3'd2,
    FMT_I32 = 3'd3,
    FMT_I64 = 3'd4
  } fmt_e;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } cls_e;

  typedef struct packed {
    logic                     valid;
    logic                     sign;
    logic signed [EXP_W-1:0]  exp;
    logic [MANT_W-1:0]        mant;
    cls_e                     cls;
    logic                     invalid;
  } unpk_t;

  // Exponent field width of float format index 0..2 (single, double, quad)
  function automatic int flt_exp_w(input int idx);
    case (idx)
      0:       return 8;
      1:       return 11;
      default: return 15;
    endcase
  endfunction

  function automatic int flt_frac_w(input int idx);
    case (idx)
      0:       return 23;
      1:       return 52;
      default: return 112;
    endcase
  endfunction
endpackage

// File: rtl/fp_flt_decode.sv
module fp_flt_decode
  import fp_unpack_pkg::*;
#(
  parameter int EXP_FW  = 8,
  parameter int FRAC_FW = 23,
  parameter int M_W     = 128,
  parameter int E_W     = 18
) (
  input  logic [EXP_FW+FRAC_FW-1:0] fields,
  output cls_e                      cls,
  output logic signed [E_W-1:0]     exp,
  output logic [M_W-1:0]            mant,
  output logic                      invalid
);
  localparam int BIAS = (1 << (EXP_FW - 1)) - 1;
  localparam logic [EXP_FW-1:0] EFIELD_MAX = '1;

  logic [EXP_FW-1:0]  efield;
  logic [FRAC_FW-1:0] frac;
  logic [M_W-1:0]     frac_al;

  assign efield  = fields[EXP_FW+FRAC_FW-1 -: EXP_FW];
  assign frac    = fields[FRAC_FW-1:0];
  assign frac_al = {1'b0, frac, {(M_W-1-FRAC_FW){1'b0}}};

  always_comb begin
    cls     = CLS_ZERO;
    exp     = '0;
    mant    = '0;
    invalid = 1'b0;
    if (efield == '0) begin
      if (frac != '0) begin
        // subnormal: no hidden one, normalized later
        cls  = CLS_NUM;
        exp  = E_W'(1 - BIAS);
        mant = frac_al;
      end
    end else if (efield == EFIELD_MAX) begin
      if (frac != '0) begin
        mant = frac_al;
        if (!frac[FRAC_FW-1]) begin
          mant[M_W-2] = 1'b1;
          cls         = CLS_SNAN;
          invalid     = 1'b1;
        end else begin
          cls = CLS_QNAN;
        end
      end else begin
        cls = CLS_INF;
      end
    end else begin
      cls  = CLS_NUM;
      exp  = E_W'(efield) - E_W'(BIAS);
      mant = frac_al | {1'b1, {(M_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/fp_int_decode.sv
module fp_int_decode
  import fp_unpack_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int M_W   = 128,
  parameter int E_W   = 18
) (
  input  logic [INT_W-1:0]      raw,
  input  logic                  is_signed,
  output cls_e                  cls,
  output logic signed [E_W-1:0] exp,
  output logic [M_W-1:0]        mant
);
  logic             neg;
  logic [INT_W-1:0] mag;

  assign neg  = is_signed & raw[INT_W-1];
  assign mag  = neg ? (INT_W'(0) - raw) : raw;
  assign cls  = (mag == '0) ? CLS_ZERO : CLS_NUM;
  assign exp  = (mag == '0) ? '0 : E_W'(INT_W - 1);
  assign mant = {mag, {(M_W-INT_W){1'b0}}};
endmodule

// File: rtl/fp_lzc.sv
module fp_lzc #(
  parameter int W   = 128,
  parameter int C_W = $clog2(W)
) (
  input  logic [W-1:0]   din,
  output logic [C_W-1:0] cnt
);
  // priority scan: the highest set bit wins
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = C_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp_lshift.sv
module fp_lshift #(
  parameter int W   = 128,
  parameter int S_W = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [S_W-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stage [S_W+1];

  assign stage[0] = din;
  for (genvar s = 0; s < S_W; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
  end
  assign dout = stage[S_W];
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
  import fp_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_operand,
  input  logic [2:0]        in_type,
  input  logic              in_signed,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [MANT_W-1:0] out_mant,
  output logic [2:0]        out_class,
  output logic              out_invalid
);
  // ---------------- stage 1: field decode ----------------
  cls_e                    flt_cls  [NUM_FLT];
  logic signed [EXP_W-1:0] flt_exp  [NUM_FLT];
  logic [MANT_W-1:0]       flt_mant [NUM_FLT];
  logic                    flt_inv  [NUM_FLT];

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    localparam int EFW = flt_exp_w(g);
    localparam int FFW = flt_frac_w(g);
    fp_flt_decode #(
      .EXP_FW (EFW),
      .FRAC_FW(FFW),
      .M_W    (MANT_W),
      .E_W    (EXP_W)
    ) u_dec (
      .fields (in_operand[OP_W-2 -: EFW+FFW]),
      .cls    (flt_cls[g]),
      .exp    (flt_exp[g]),
      .mant   (flt_mant[g]),
      .invalid(flt_inv[g])
    );
  end

  cls_e                    int_cls  [NUM_INT];
  logic signed [EXP_W-1:0] int_exp  [NUM_INT];
  logic [MANT_W-1:0]       int_mant [NUM_INT];

  for (genvar g = 0; g < NUM_INT; g++) begin : g_int
    localparam int IW = 32 << g;
    fp_int_decode #(
      .INT_W(IW),
      .M_W  (MANT_W),
      .E_W  (EXP_W)
    ) u_dec (
      .raw      (in_operand[OP_W-1 -: IW]),
      .is_signed(in_signed),
      .cls      (int_cls[g]),
      .exp      (int_exp[g]),
      .mant     (int_mant[g])
    );
  end

  logic  accept;
  unpk_t dec;
  unpk_t s1_q;

  assign accept = in_valid && in_ready;

  always_comb begin
    dec       = '0;
    dec.valid = accept;
    dec.sign  = in_operand[OP_W-1];
    case (in_type)
      FMT_SP, FMT_DP, FMT_QP: begin
        dec.cls     = flt_cls[in_type[1:0]];
        dec.exp     = flt_exp[in_type[1:0]];
        dec.mant    = flt_mant[in_type[1:0]];
        dec.invalid = flt_inv[in_type[1:0]];
      end
      FMT_I32: begin
        dec.cls  = int_cls[0];
        dec.exp  = int_exp[0];
        dec.mant = int_mant[0];
      end
      FMT_I64: begin
        dec.cls  = int_cls[1];
        dec.exp  = int_exp[1];
        dec.mant = int_mant[1];
      end
      default: ; // reserved codes stay class zero
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q     <= '0;
      in_ready <= 1'b0;
    end else begin
      s1_q     <= dec;
      in_ready <= 1'b1;
    end
  end

  // ---------------- stage 2: normalize ----------------
  logic [CNT_W-1:0]  lz_cnt;
  logic [MANT_W-1:0] mant_norm;

  fp_lzc #(.W(MANT_W), .C_W(CNT_W)) u_lzc (
    .din(s1_q.mant),
    .cnt(lz_cnt)
  );

  fp_lshift #(.W(MANT_W), .S_W(CNT_W)) u_shift (
    .din (s1_q.mant),
    .amt (lz_cnt),
    .dout(mant_norm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_mant    <= '0;
      out_class   <= CLS_ZERO;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= s1_q.valid;
      if (s1_q.valid) begin
        out_sign    <= s1_q.sign;
        out_class   <= s1_q.cls;
        out_invalid <= s1_q.invalid;
        if (s1_q.cls == CLS_NUM) begin
          out_mant <= mant_norm;
          out_exp  <= s1_q.exp - EXP_W'(lz_cnt);
        end else begin
          out_mant <= s1_q.mant;
          out_exp  <= s1_q.exp;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    s1_q.valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !s1_q.valid |=> !out_valid);
  p_zero_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == CLS_ZERO) |-> (out_mant == '0 && out_exp == '0));
  p_num_leading_one_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_q.valid && s1_q.cls == CLS_NUM) |=> out_mant[MANT_W-1]);
  p_inf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == CLS_INF) |-> (out_mant == '0));
  p_snan_quieted_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == CLS_SNAN) |-> (out_mant[MANT_W-2] && out_invalid));
  p_invalid_only_snan_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (out_class == CLS_SNAN));
endmodule

// File: tb/fp_unpack_tb_top.sv
`timescale 1ns/1ps
module fp_unpack_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_operand = '0;
  logic [2:0]   in_type = '0;
  logic         in_signed = 1'b0;
  logic         out_valid;
  logic         out_sign;
  logic [17:0]  out_exp;
  logic [127:0] out_mant;
  logic [2:0]   out_class;
  logic         out_invalid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fp_unpack dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_type(in_type), .in_signed(in_signed),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_mant(out_mant), .out_class(out_class), .out_invalid(out_invalid)
  );

  // class codes per R3..R8
  localparam logic [2:0] K_ZERO = 3'd0, K_NUM = 3'd1, K_INF = 3'd2,
                         K_QNAN = 3'd3, K_SNAN = 3'd4;
  localparam logic [95:0] JUNK96 = 96'hDEAD_BEEF_0123_4567_89AB_CDEF;
  localparam logic [63:0] JUNK64 = 64'hA5A5_5A5A_F00D_1234;

  typedef struct packed {
    logic [2:0]   t;
    logic         sg;
    logic [127:0] op;
    logic [2:0]   cls;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, {32'h0000_0000, JUNK96}, K_ZERO},
    '{3'd0, 1'b0, {32'h8000_0000, 96'h0},  K_ZERO},
    '{3'd0, 1'b0, {32'h0000_0001, JUNK96}, K_NUM},
    '{3'd0, 1'b0, {32'h007F_FFFF, 96'h0},  K_NUM},
    '{3'd0, 1'b0, {32'h0080_0000, 96'h0},  K_NUM},
    '{3'd0, 1'b0, {32'h3F80_0000, JUNK96}, K_NUM},
    '{3'd0, 1'b0, {32'hC2F6_E979, 96'h0},  K_NUM},
    '{3'd0, 1'b0, {32'h7F7F_FFFF, 96'h0},  K_NUM},
    '{3'd0, 1'b0, {32'h7F80_0000, JUNK96}, K_INF},
    '{3'd0, 1'b0, {32'hFF80_0000, 96'h0},  K_INF},
    '{3'd0, 1'b0, {32'h7FC0_0000, 96'h0},  K_QNAN},
    '{3'd0, 1'b0, {32'hFFC0_0001, JUNK96}, K_QNAN},
    '{3'd0, 1'b0, {32'h7F80_0001, 96'h0},  K_SNAN},
    '{3'd0, 1'b0, {32'h7FBF_FFFF, JUNK96}, K_SNAN},
    '{3'd1, 1'b0, {64'h0, JUNK64},                 K_ZERO},
    '{3'd1, 1'b0, {64'h0000_0000_0000_0001, 64'h0}, K_NUM},
    '{3'd1, 1'b0, {64'h000F_FFFF_FFFF_FFFF, 64'h0}, K_NUM},
    '{3'd1, 1'b0, {64'h3FF0_0000_0000_0000, JUNK64}, K_NUM},
    '{3'd1, 1'b0, {64'h7FEF_FFFF_FFFF_FFFF, 64'h0}, K_NUM},
    '{3'd1, 1'b0, {64'hFFF0_0000_0000_0000, 64'h0}, K_INF},
    '{3'd1, 1'b0, {64'h7FF8_0000_0000_0000, 64'h0}, K_QNAN},
    '{3'd1, 1'b0, {64'h7FF0_0000_0000_0001, JUNK64}, K_SNAN},
    '{3'd2, 1'b0, 128'h0, K_ZERO},
    '{3'd2, 1'b0, 128'h1, K_NUM},
    '{3'd2, 1'b0, {16'h3FFF, 112'h0}, K_NUM},
    '{3'd2, 1'b0, {16'h7FFE, {112{1'b1}}}, K_NUM},
    '{3'd2, 1'b0, {16'h7FFF, 112'h0}, K_INF},
    '{3'd2, 1'b0, {16'h7FFF, 1'b1, 111'h5}, K_QNAN},
    '{3'd2, 1'b0, {16'hFFFF, 112'h1}, K_SNAN},
    '{3'd3, 1'b1, {32'h0000_0000, JUNK96}, K_ZERO},
    '{3'd3, 1'b1, {32'h0000_0001, 96'h0},  K_NUM},
    '{3'd3, 1'b1, {32'hFFFF_FFFF, JUNK96}, K_NUM},
    '{3'd3, 1'b1, {32'h8000_0000, 96'h0},  K_NUM},
    '{3'd3, 1'b0, {32'h8000_0000, 96'h0},  K_NUM},
    '{3'd3, 1'b0, {32'hFFFF_FFFF, 96'h0},  K_NUM},
    '{3'd4, 1'b1, {64'h8000_0000_0000_0000, JUNK64}, K_NUM},
    '{3'd4, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, K_NUM},
    '{3'd4, 1'b1, {64'h0000_0000_0000_0005, 64'h0}, K_NUM},
    '{3'd5, 1'b0, {32'h3F80_0000, 96'h0}, K_ZERO},
    '{3'd7, 1'b1, {32'h7F80_0001, 96'h0}, K_ZERO}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Reference model written from the requirements
  function automatic void model(input logic [2:0] t, input logic sg, input logic [127:0] op,
                                output logic [2:0] cls, output logic sgn, output int e,
                                output logic [127:0] m, output logic inv, output string tag);
    int ew, fw, w, bias, ef;
    logic [127:0] fa;
    logic [63:0] v;
    cls = K_ZERO; sgn = op[127]; e = 0; m = '0; inv = 1'b0; tag = "R3";
    if (t <= 3'd2) begin
      ew = (t == 3'd0) ? 8 : (t == 3'd1) ? 11 : 15;
      fw = (t == 3'd0) ? 23 : (t == 3'd1) ? 52 : 112;
      bias = (1 << (ew - 1)) - 1;
      ef = int'((op >> (127 - ew)) & ((128'd1 << ew) - 128'd1));
      fa = (op << (1 + ew)) & ~({128{1'b1}} >> fw);
      if (ef == 0 && fa == '0) begin
        tag = "R3";
      end else if (ef == 0) begin
        cls = K_NUM; tag = "R5"; m = fa >> 1; e = 1 - bias;
        while (!m[127]) begin m = m << 1; e = e - 1; end
      end else if (ef == (1 << ew) - 1) begin
        if (fa == '0) begin
          cls = K_INF; tag = "R6";
        end else begin
          m = fa >> 1;
          if (!m[126]) begin
            cls = K_SNAN; tag = "R8"; m[126] = 1'b1; inv = 1'b1;
          end else begin
            cls = K_QNAN; tag = "R7";
          end
        end
      end else begin
        cls = K_NUM; tag = "R4"; m = (fa >> 1) | {1'b1, 127'h0}; e = ef - bias;
      end
    end else if (t == 3'd3 || t == 3'd4) begin
      w = (t == 3'd3) ? 32 : 64;
      v = 64'(op >> (128 - w));
      tag = "R10";
      if (sg && v[w-1]) begin
        v = (~v + 64'd1) & ((w == 64) ? {64{1'b1}} : 64'hFFFF_FFFF);
        tag = "R9";
      end
      if (v == '0) begin
        tag = "R3";
      end else begin
        cls = K_NUM; m = 128'(v) << (128 - w); e = w - 1;
        while (!m[127]) begin m = m << 1; e = e - 1; end
      end
    end else begin
      tag = "R11";
    end
  endfunction

  task automatic compare(input vec_t vv);
    logic [2:0] c; logic s; int e; logic [127:0] m; logic iv; string tg;
    model(vv.t, vv.sg, vv.op, c, s, e, m, iv, tg);
    chk(out_valid === 1'b1, "R2", "out_valid at +2", 128'(out_valid), 128'd1);
    chk(out_class === vv.cls && c == vv.cls, tg, "class", 128'(out_class), 128'(vv.cls));
    chk(out_sign === s, "R1", "sign", 128'(out_sign), 128'(s));
    chk(out_exp === 18'(e), tg, "exp", 128'(out_exp), 128'(18'(e)));
    chk(out_mant === m, tg, "mant", out_mant, m);
    chk(out_invalid === iv, "R8", "invalid", 128'(out_invalid), 128'(iv));
  endtask

  task automatic run_vec(input vec_t vv);
    @(negedge clk);
    in_type = vv.t; in_signed = vv.sg; in_operand = vv.op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b0, "R2", "out_valid at +1", 128'(out_valid), 128'd0);
    @(negedge clk);
    compare(vv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b0, "R2", "in_ready in reset", 128'(in_ready), 128'd0);
    chk(out_valid === 1'b0, "R2", "out_valid in reset", 128'(out_valid), 128'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1, "R2", "in_ready after reset", 128'(in_ready), 128'd1);
    chk(out_valid === 1'b0, "R2", "out_valid idle", 128'(out_valid), 128'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R2: back-to-back acceptance, results in consecutive cycles
    @(negedge clk);
    in_type = VECS[7].t; in_signed = VECS[7].sg; in_operand = VECS[7].op; in_valid = 1'b1;
    @(negedge clk);
    in_type = VECS[35].t; in_signed = VECS[35].sg; in_operand = VECS[35].op;
    @(negedge clk);
    in_valid = 1'b0;
    compare(VECS[7]);
    @(negedge clk);
    compare(VECS[35]);
    @(negedge clk);
    chk(out_valid === 1'b0, "R2", "out_valid after burst", 128'(out_valid), 128'd0);

    // R1: bits below a single operand have no effect on the result
    run_vec('{3'd0, 1'b0, {32'h4049_0FDB, {96{1'b1}}}, K_NUM});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule